// File: doc/BRIEF.md
# Wormhole Output Allocation and Credit Control

This block is the control plane of a small single-cycle wormhole router with N inputs and N outputs. Each input shows the flit at the front of its buffer: a valid bit, a two-bit flit kind and a one-hot destination output. In the same cycle, the block decides which inputs may request which outputs. It runs one round-robin arbiter per output and returns one-hot grants. The grants dequeue the flits and steer the crossbar. Routing computation, the flit buffers and the crossbar datapath sit outside the block.

Every output has an availability flag and a credit counter. The counter mirrors the free slots of the buffer one hop downstream. The flag is cleared when a head flit claims the output and set again when the tail flit leaves. The flag and the counter are both updated from the plain fact that some request of the right kind targets the output. They never use the identity of the arbitration winner, so both updates run side by side with arbitration rather than after it. A small per-output owner register records which input holds the output, so that only that input's body and tail flits may use it.

Top module: `wh_alloc_ctrl`

## Requirements
- R1: Flit kind codes are 1 = head, 2 = body, 3 = tail (0 = no flit). A head flit raises a request only while its destination's availability flag is set. A body or tail flit raises a request only when its input is the recorded owner of the destination. Any other flit gets no grant.
- R2: An output's availability flag is cleared at the end of any cycle in which at least one head request targets it, whether or not that head wins. A losing head gets no grant until the output is released.
- R3: A tail request to an output sets its availability flag and clears its owner at the end of that cycle. A head from another input can win that output in the following cycle, but not in the tail's own cycle.
- R4: A request is raised only when the destination's credit count is nonzero. Each cycle with at least one request to an output takes one credit from it.
- R5: Each credit return pulse adds one credit, usable from the next cycle. A return and a consume in the same cycle leave the count unchanged. The count saturates at CRED_DEPTH.
- R6: Each output arbiter is round-robin. The search starts at the input after the last head winner, with input 0 first after reset. The pointer moves only when a head flit is granted.
- R7: A granted input's dequeue grant rises in the same cycle. The crossbar select of output j (bits j*N+N-1 down to j*N) is one-hot on the granted input, and out_vld[j] is set. Outputs with distinct winners are granted in parallel.
- R8: Back-to-back three-flit packets from one input to one output are granted one flit per cycle, with no idle cycle between packets, while credits last.
- R9: After reset, every availability flag is set and every credit counter holds CRED_DEPTH. No grant is given without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| flit_vld | input | N_PORTS | Front flit valid, one bit per input |
| flit_kind | input | 2*N_PORTS | Front flit kind per input, bits 2i+1..2i |
| flit_dest | input | N_PORTS*N_PORTS | One-hot destination per input, bits i*N+N-1..i*N |
| cred_ret | input | N_PORTS | Credit return pulse per output from downstream |
| deq_gnt | output | N_PORTS | Dequeue grant per input |
| xbar_sel | output | N_PORTS*N_PORTS | One-hot input select per output, bits j*N+N-1..j*N |
| out_vld | output | N_PORTS | Flit leaving on each output this cycle |

## Verification
The assertions check several properties on every cycle. Grants are one-hot and never exceed the requests, and no input is granted two outputs. The credit count stays within its bound, drops by one on an uncredited consume, and is nonzero whenever a request exists. Owners are one-hot and empty on a free output. The flag follows head and tail requests, and the arbiter pointer holds when no head wins. Only the bench scenarios can show the timing seen at the ports. These cover the one-cycle delay before a released output is visible, the round-robin winner order, the stall and resume when credits run out, saturation at the buffer depth, and the gap-free flow of consecutive packets.

// File: rtl/wh_alloc_pkg.sv
package wh_alloc_pkg;

  typedef enum logic [1:0] {
    FK_IDLE = 2'd0,
    FK_HEAD = 2'd1,
    FK_BODY = 2'd2,
    FK_TAIL = 2'd3
  } flit_kind_e;

endpackage

// File: rtl/wh_rst_sync.sv
module wh_rst_sync (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_no = sync_q;

endmodule

// File: rtl/wh_req_gen.sv
module wh_req_gen
  import wh_alloc_pkg::*;
#(
  parameter int N_PORTS = 4
) (
  input  logic               flit_vld,
  input  logic [1:0]         flit_kind,
  input  logic [N_PORTS-1:0] flit_dest,
  input  logic [N_PORTS-1:0] avail,
  input  logic [N_PORTS-1:0] hold,
  input  logic [N_PORTS-1:0] cred_ok,
  output logic [N_PORTS-1:0] req,
  output logic               is_head,
  output logic               is_tail
);

  flit_kind_e         kind;
  logic [N_PORTS-1:0] state_ok;
  logic [N_PORTS-1:0] dest_live;

  always_comb begin
    kind    = flit_kind_e'(flit_kind);
    is_head = flit_vld && (kind == FK_HEAD);
    is_tail = flit_vld && (kind == FK_TAIL);
  end

  // a head needs a free output; body and tail need ownership
  always_comb begin
    dest_live = flit_vld ? flit_dest : '0;
    unique case (kind)
      FK_HEAD:         state_ok = avail;
      FK_BODY, FK_TAIL: state_ok = hold;
      default:         state_ok = '0;
    endcase
  end

  always_comb begin
    req = dest_live & state_ok & cred_ok;
  end

endmodule

// File: rtl/wh_rr_arb.sv
module wh_rr_arb #(
  parameter int N_PORTS = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_PORTS-1:0] req,
  input  logic [N_PORTS-1:0] head,
  output logic [N_PORTS-1:0] gnt
);

  localparam int IW = (N_PORTS > 1) ? $clog2(N_PORTS) : 1;
  localparam logic [IW:0] NWRAP = (IW+1)'(N_PORTS);

  logic [IW-1:0] ptr_q;
  logic [IW-1:0] ptr_d;
  logic [IW-1:0] win;
  logic [IW:0]   pos;
  logic          found;
  logic          adv;

  // search starts one past the last head winner
  always_comb begin
    gnt   = '0;
    win   = ptr_q;
    found = 1'b0;
    pos   = '0;
    for (int k = 0; k < N_PORTS; k++) begin
      pos = {1'b0, ptr_q} + (IW+1)'(k + 1);
      if (pos >= NWRAP) pos = pos - NWRAP;
      if (!found && req[pos[IW-1:0]]) begin
        gnt[pos[IW-1:0]] = 1'b1;
        win              = pos[IW-1:0];
        found            = 1'b1;
      end
    end
  end

  always_comb begin
    adv   = |(gnt & head);
    ptr_d = adv ? win : ptr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= IW'(N_PORTS - 1);
    end else if (adv) begin
      ptr_q <= ptr_d;
    end
  end

  // R7
  gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  // R7
  gnt_in_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & ~req) == '0);

  // R7
  work_conserve_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|req) |-> (|gnt));

  // R6
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(ptr_q));

endmodule

// File: rtl/wh_out_state.sv
module wh_out_state #(
  parameter int N_PORTS    = 4,
  parameter int CRED_DEPTH = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               head_req,
  input  logic               tail_req,
  input  logic               any_req,
  input  logic               ret,
  input  logic [N_PORTS-1:0] gnt,
  output logic               avail,
  output logic [N_PORTS-1:0] hold,
  output logic               cred_ok
);

  localparam int          CW   = $clog2(CRED_DEPTH + 1);
  localparam logic [CW-1:0] FULL = CW'(CRED_DEPTH);

  logic               avail_q, avail_d, avail_en;
  logic [N_PORTS-1:0] hold_q, hold_d;
  logic               hold_en;
  logic [CW-1:0]      cnt_q, cnt_d;
  logic               cnt_en;

  // lock and release use only the presence of a request
  always_comb begin
    avail_en = head_req || tail_req;
    avail_d  = tail_req;
    hold_en  = head_req || tail_req;
    hold_d   = tail_req ? '0 : gnt;
  end

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    unique case ({ret, any_req})
      2'b10: begin
        cnt_en = (cnt_q != FULL);
        cnt_d  = cnt_q + CW'(1);
      end
      2'b01: begin
        cnt_en = 1'b1;
        cnt_d  = cnt_q - CW'(1);
      end
      default: begin
        cnt_en = 1'b0;
        cnt_d  = cnt_q;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      avail_q <= 1'b1;
      hold_q  <= '0;
      cnt_q   <= FULL;
    end else begin
      if (avail_en) avail_q <= avail_d;
      if (hold_en)  hold_q  <= hold_d;
      if (cnt_en)   cnt_q   <= cnt_d;
    end
  end

  always_comb begin
    avail   = avail_q;
    hold    = hold_q;
    cred_ok = (cnt_q != '0);
  end

  // R2
  head_locks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    head_req |=> !avail_q);

  // R3
  tail_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tail_req |=> (avail_q && hold_q == '0));

  // R5
  cred_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL);

  // R4
  cred_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (any_req && !ret) |=> (cnt_q == $past(cnt_q) - CW'(1)));

  // R4
  req_has_cred_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_req |-> (cnt_q != '0));

  // R1
  owner_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hold_q));

  // R1
  free_no_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    avail_q |-> (hold_q == '0));

endmodule

// File: rtl/wh_alloc_ctrl.sv
module wh_alloc_ctrl #(
  parameter int N_PORTS    = 4,
  parameter int CRED_DEPTH = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [N_PORTS-1:0]           flit_vld,
  input  logic [2*N_PORTS-1:0]         flit_kind,
  input  logic [N_PORTS*N_PORTS-1:0]   flit_dest,
  input  logic [N_PORTS-1:0]           cred_ret,
  output logic [N_PORTS-1:0]           deq_gnt,
  output logic [N_PORTS*N_PORTS-1:0]   xbar_sel,
  output logic [N_PORTS-1:0]           out_vld
);

  localparam int N = N_PORTS;

  logic                 rst_s;
  logic [N-1:0][N-1:0]  req_io;
  logic [N-1:0][N-1:0]  req_oi;
  logic [N-1:0][N-1:0]  hold_oi;
  logic [N-1:0][N-1:0]  hold_io;
  logic [N-1:0][N-1:0]  gnt_oi;
  logic [N-1:0][N-1:0]  gnt_io;
  logic [N-1:0]         avail;
  logic [N-1:0]         cred_ok;
  logic [N-1:0]         is_head;
  logic [N-1:0]         is_tail;
  logic [N-1:0]         head_any;
  logic [N-1:0]         tail_any;
  logic [N-1:0]         req_any;

  wh_rst_sync u_rst (
    .clk    (clk),
    .rst_ni (rst_n),
    .rst_no (rst_s)
  );

  always_comb begin
    for (int j = 0; j < N; j++)
      for (int i = 0; i < N; i++)
        hold_io[i][j] = hold_oi[j][i];
  end

  always_comb begin
    for (int j = 0; j < N; j++)
      for (int i = 0; i < N; i++)
        req_oi[j][i] = req_io[i][j];
  end

  always_comb begin
    for (int j = 0; j < N; j++)
      for (int i = 0; i < N; i++)
        gnt_io[i][j] = gnt_oi[j][i];
  end

  always_comb begin
    for (int j = 0; j < N; j++) begin
      head_any[j] = |(req_oi[j] & is_head);
      tail_any[j] = |(req_oi[j] & is_tail);
      req_any[j]  = |req_oi[j];
    end
  end

  genvar gi;
  generate
    for (gi = 0; gi < N; gi++) begin : g_in
      wh_req_gen #(.N_PORTS(N)) u_req (
        .flit_vld  (flit_vld[gi]),
        .flit_kind (flit_kind[2*gi +: 2]),
        .flit_dest (flit_dest[N*gi +: N]),
        .avail     (avail),
        .hold      (hold_io[gi]),
        .cred_ok   (cred_ok),
        .req       (req_io[gi]),
        .is_head   (is_head[gi]),
        .is_tail   (is_tail[gi])
      );

      // R7
      one_out_per_in_chk: assert property (@(posedge clk) disable iff (!rst_s)
        $onehot0(gnt_io[gi]));

      // R7
      deq_needs_flit_chk: assert property (@(posedge clk) disable iff (!rst_s)
        deq_gnt[gi] |-> flit_vld[gi]);
    end

    for (gi = 0; gi < N; gi++) begin : g_out
      wh_rr_arb #(.N_PORTS(N)) u_arb (
        .clk   (clk),
        .rst_n (rst_s),
        .req   (req_oi[gi]),
        .head  (is_head),
        .gnt   (gnt_oi[gi])
      );

      wh_out_state #(.N_PORTS(N), .CRED_DEPTH(CRED_DEPTH)) u_state (
        .clk      (clk),
        .rst_n    (rst_s),
        .head_req (head_any[gi]),
        .tail_req (tail_any[gi]),
        .any_req  (req_any[gi]),
        .ret      (cred_ret[gi]),
        .gnt      (gnt_oi[gi]),
        .avail    (avail[gi]),
        .hold     (hold_oi[gi]),
        .cred_ok  (cred_ok[gi])
      );
    end
  endgenerate

  always_comb begin
    for (int i = 0; i < N; i++) deq_gnt[i] = |gnt_io[i];
  end

  always_comb begin
    for (int j = 0; j < N; j++) begin
      out_vld[j]          = |gnt_oi[j];
      xbar_sel[N*j +: N]  = gnt_oi[j];
    end
  end

endmodule

// File: tb/wh_alloc_ctrl_tb.sv
module wh_alloc_ctrl_tb;

  localparam int N    = 4;
  localparam int DEP  = 4;
  localparam real HALF = 2.5;

  logic             clk;
  logic             rst_n;
  logic [N-1:0]     flit_vld;
  logic [2*N-1:0]   flit_kind;
  logic [N*N-1:0]   flit_dest;
  logic [N-1:0]     cred_ret;
  logic [N-1:0]     deq_gnt;
  logic [N*N-1:0]   xbar_sel;
  logic [N-1:0]     out_vld;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  logic [N-1:0]   q_g[$];
  logic [N*N-1:0] q_s[$];
  logic [N-1:0]   q_o[$];
  string          q_t[$];

  wh_alloc_ctrl #(.N_PORTS(N), .CRED_DEPTH(DEP)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .flit_vld  (flit_vld),
    .flit_kind (flit_kind),
    .flit_dest (flit_dest),
    .cred_ret  (cred_ret),
    .deq_gnt   (deq_gnt),
    .xbar_sel  (xbar_sel),
    .out_vld   (out_vld)
  );

  initial clk = 1'b0;
  always #(HALF) clk = ~clk;

  // driver: apply one cycle of stimulus and queue its expected result
  task automatic step(input logic [N-1:0] v, input logic [2*N-1:0] k,
                      input logic [N*N-1:0] d, input logic [N-1:0] cr,
                      input logic [N-1:0] eg, input string tag);
    logic [N*N-1:0] es;
    logic [N-1:0]   eo;
    @(negedge clk);
    flit_vld  = v;
    flit_kind = k;
    flit_dest = d;
    cred_ret  = cr;
    es = '0;
    eo = '0;
    for (int j = 0; j < N; j++)
      for (int i = 0; i < N; i++)
        if (eg[i] && d[i*N+j]) begin
          es[j*N+i] = 1'b1;
          eo[j]     = 1'b1;
        end
    q_g.push_back(eg);
    q_s.push_back(es);
    q_o.push_back(eo);
    q_t.push_back(tag);
  endtask

  // monitor: compare shortly after the inputs settle, before the next edge
  initial begin
    forever begin
      @(negedge clk);
      #1.5;
      if (q_g.size() > 0) begin
        logic [N-1:0]   eg;
        logic [N*N-1:0] es;
        logic [N-1:0]   eo;
        string          t;
        eg = q_g.pop_front();
        es = q_s.pop_front();
        eo = q_o.pop_front();
        t  = q_t.pop_front();
        tests++;
        if (deq_gnt !== eg || xbar_sel !== es || out_vld !== eo) begin
          fails++;
          $display("FAIL %s: actual deq=%b sel=%h vld=%b expected deq=%b sel=%h vld=%b",
                   t, deq_gnt, xbar_sel, out_vld, eg, es, eo);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL R8 watchdog: actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n     = 1'b1;
    flit_vld  = '0;
    flit_kind = '0;
    flit_dest = '0;
    cred_ret  = '0;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // reset state
    step(4'h0, 8'h00, 16'h0000, 4'h0, 4'h0, "R9 idle after reset");

    // in0 to out2, two packets back to back, credit returned every cycle
    step(4'h1, 8'h01, 16'h0004, 4'h4, 4'h1, "R9 first head uses reset credits");
    step(4'h1, 8'h02, 16'h0004, 4'h4, 4'h1, "R8 body");
    step(4'h1, 8'h03, 16'h0004, 4'h4, 4'h1, "R8 tail");
    step(4'h1, 8'h01, 16'h0004, 4'h4, 4'h1, "R8 next head without gap");
    step(4'h1, 8'h02, 16'h0004, 4'h4, 4'h1, "R8 body 2");
    step(4'h1, 8'h03, 16'h0004, 4'h4, 4'h1, "R5 tail with return and consume");
    step(4'h0, 8'h00, 16'h0000, 4'h0, 4'h0, "R7 idle");

    // credit exhaustion on out2
    step(4'h1, 8'h01, 16'h0004, 4'h0, 4'h1, "R4 credit 4 of 4");
    step(4'h1, 8'h02, 16'h0004, 4'h0, 4'h1, "R4 credit 3 of 4");
    step(4'h1, 8'h03, 16'h0004, 4'h0, 4'h1, "R4 credit 2 of 4");
    step(4'h1, 8'h01, 16'h0004, 4'h0, 4'h1, "R4 last credit");
    step(4'h1, 8'h02, 16'h0004, 4'h0, 4'h0, "R4 stall at zero credits");
    step(4'h1, 8'h02, 16'h0004, 4'h4, 4'h0, "R5 return not usable same cycle");
    step(4'h1, 8'h02, 16'h0004, 4'h0, 4'h1, "R5 returned credit used");
    step(4'h1, 8'h03, 16'h0004, 4'h4, 4'h0, "R4 tail waits for credit");
    step(4'h1, 8'h03, 16'h0004, 4'h4, 4'h1, "R5 return and consume together");
    for (int c = 0; c < 6; c++)
      step(4'h0, 8'h00, 16'h0000, 4'h4, 4'h0, "R5 excess returns");
    step(4'h1, 8'h01, 16'h0004, 4'h0, 4'h1, "R5 saturated flit 1");
    step(4'h1, 8'h02, 16'h0004, 4'h0, 4'h1, "R5 saturated flit 2");
    step(4'h1, 8'h03, 16'h0004, 4'h0, 4'h1, "R5 saturated flit 3");
    step(4'h1, 8'h01, 16'h0004, 4'h0, 4'h1, "R5 saturated flit 4");
    step(4'h1, 8'h02, 16'h0004, 4'h0, 4'h0, "R5 count capped at depth");
    step(4'h1, 8'h02, 16'h0004, 4'h4, 4'h0, "R4 body waits");
    step(4'h1, 8'h02, 16'h0004, 4'h0, 4'h1, "R4 body resumes");
    step(4'h1, 8'h03, 16'h0004, 4'h4, 4'h0, "R4 tail waits");
    step(4'h1, 8'h03, 16'h0004, 4'h4, 4'h1, "R4 tail resumes");
    for (int c = 0; c < 4; c++)
      step(4'h0, 8'h00, 16'h0000, 4'h4, 4'h0, "R5 refill");

    // contention on out0 between in0 and in1
    step(4'h3, 8'h05, 16'h0011, 4'h1, 4'h1, "R6 input 0 first after reset");
    step(4'h3, 8'h06, 16'h0011, 4'h1, 4'h1, "R2 losing head blocked");
    step(4'h3, 8'h07, 16'h0011, 4'h1, 4'h1, "R3 release not visible in tail cycle");
    step(4'h2, 8'h04, 16'h0011, 4'h1, 4'h2, "R3 released output taken");
    step(4'h2, 8'h08, 16'h0011, 4'h1, 4'h2, "R1 owner body");
    step(4'h2, 8'h0C, 16'h0011, 4'h1, 4'h2, "R1 owner tail");

    // round-robin order
    step(4'h7, 8'h15, 16'h0111, 4'h1, 4'h4, "R6 input 2 follows last winner 1");
    step(4'h7, 8'h25, 16'h0111, 4'h1, 4'h4, "R6 held through body");
    step(4'h7, 8'h35, 16'h0111, 4'h1, 4'h4, "R6 held through tail");
    step(4'h3, 8'h05, 16'h0011, 4'h1, 4'h1, "R6 wrap to input 0");
    step(4'h3, 8'h06, 16'h0011, 4'h1, 4'h1, "R2 input 1 still blocked");
    step(4'h3, 8'h07, 16'h0011, 4'h1, 4'h1, "R3 tail of input 0");
    step(4'h2, 8'h04, 16'h0011, 4'h1, 4'h2, "R6 input 1 head");
    step(4'h2, 8'h08, 16'h0011, 4'h1, 4'h2, "R8 input 1 body");
    step(4'h2, 8'h0C, 16'h0011, 4'h1, 4'h2, "R8 input 1 tail");

    // non-owner body flits on out1
    step(4'h1, 8'h01, 16'h0022, 4'h2, 4'h1, "R1 head takes free output");
    step(4'h3, 8'h0A, 16'h0022, 4'h2, 4'h1, "R1 non-owner body refused");
    step(4'h3, 8'h0B, 16'h0022, 4'h2, 4'h1, "R1 owner tail only");
    step(4'h2, 8'h08, 16'h0022, 4'h2, 4'h0, "R1 body on free output refused");
    step(4'h0, 8'h00, 16'h0000, 4'h0, 4'h0, "R7 idle");

    // four disjoint packets in parallel
    step(4'hF, 8'h55, 16'h8421, 4'hF, 4'hF, "R7 four heads in parallel");
    step(4'hF, 8'hAA, 16'h8421, 4'hF, 4'hF, "R7 four bodies in parallel");
    step(4'hF, 8'hFF, 16'h8421, 4'hF, 4'hF, "R7 four tails in parallel");
    step(4'h0, 8'h00, 16'h0000, 4'h0, 4'h0, "R7 final idle");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule